// File: doc/BRIEF.md
# Triggered Circular Trace Capture Buffer

This block stores a stream of trace words in an on-chip RAM that wraps around as a ring. Software clears the write pointer, loads a post-trigger word count and sets the enable bit. From then on, every accepted word is written at the write pointer, and the pointer advances modulo the RAM depth. A trigger pulse marks the event of interest. Once the trigger has been seen, each further accepted word decrements the post-trigger counter. When the counter reaches zero, acquisition is complete and the input stops accepting words.

After the capture, software uses four sticky flags to work out where the valid history begins: Full, Triggered, Complete and Drained. If Full is clear, the write pointer is the number of stored words. If Full is set, the write pointer addresses the oldest word. Software loads the read pointer and unloads the ring through the data register. Each read of that register returns the addressed word and advances the read pointer.

The trace input is a valid/ready stream. A word transfers on a rising clock edge where both `in_valid` and `in_ready` are high. `in_ready` is low while capture is disabled, and low once the post-trigger count is exhausted. A source that sees `in_ready` low must keep its word and hold `in_valid` until the word is taken. Each accepted word spends one cycle in a staging register before it is written to the RAM. The control and register pins are plain strobes with no handshake.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset, the registers read as follows. Address 0 (depth) reads DEPTH, address 1 (width) reads WIDTH, address 2 (status) reads 8, and addresses 4 (read pointer), 5 (write pointer), 6 (trigger count) and 7 (control) read 0. Writes to addresses 0 and 1 have no effect.
- R2: `in_ready` is high only while control bit 0 (enable) is 1. While it is 0, no word is taken.
- R3: Control bit 1 drives `demux_mode`, and a read of address 7 returns both control bits.
- R4: Each accepted word is stored at the write pointer, and the pointer then advances by one modulo DEPTH. Without a wrap, the pointer equals the number of stored words.
- R5: Status bit 0 (Full) sets when a word is stored at address DEPTH-1. It stays set until the next capture start.
- R6: Status bit 1 (Triggered) sets on a `trig_in` pulse only while enable is 1.
- R7: With a trigger count of N, exactly N words are accepted after the cycle in which the trigger was seen. Status bit 2 (Complete) then sets, and `in_ready` stays low. With N = 0, completion follows the trigger directly.
- R8: Status bit 3 (Drained) is 0 exactly while an accepted word waits in the staging register.
- R9: A read of address 3 returns the word at the read pointer and advances the read pointer modulo DEPTH. Register read data appears the cycle after `reg_rd` and is held until the next read.
- R10: Writing enable from 0 to 1 clears Full, Triggered and Complete.
- R11: Words come out of the RAM in the order and with the values they were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Trace word valid |
| in_data | input | WIDTH | Trace word |
| in_ready | output | 1 | Buffer can take a word |
| trig_in | input | 1 | Trigger event pulse |
| demux_mode | output | 1 | Demultiplexed input mode select (control bit 1) |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |

## Verification
The embedded properties hold on every cycle for the following:
- the input is gated by enable and by completion;
- the write pointer stays inside the RAM;
- Full is sticky;
- the flags clear on a capture start;
- the post-trigger counter never rises without a load;
- the read pointer steps on each data read.

Other behaviours can only be shown by the bench scenarios:
- the exact number of words taken after a trigger;
- the boundary where Full first sets;
- the oldest-first order of data read back after a wrap;
- a trigger being ignored while disabled.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  typedef enum logic [2:0] {
    RA_DEPTH  = 3'd0,
    RA_WIDTH  = 3'd1,
    RA_STATUS = 3'd2,
    RA_DATA   = 3'd3,
    RA_RPTR   = 3'd4,
    RA_WPTR   = 3'd5,
    RA_TCNT   = 3'd6,
    RA_CTRL   = 3'd7
  } tcb_addr_e;

  localparam int ST_FULL    = 0;
  localparam int ST_TRIG    = 1;
  localparam int ST_DONE    = 2;
  localparam int ST_DRAINED = 3;
endpackage

// File: rtl/tcb_ram.sv
module tcb_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 24,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tcb_acq.sv
module tcb_acq #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 24,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic             trig,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  input  logic             wptr_ld,
  input  logic [AW-1:0]    wptr_val,
  input  logic             cnt_ld,
  input  logic [CW-1:0]    cnt_val,
  output logic             ram_we,
  output logic [AW-1:0]    ram_waddr,
  output logic [WIDTH-1:0] ram_wdata,
  output logic [AW-1:0]    wptr,
  output logic [CW-1:0]    cnt,
  output logic [3:0]       status
);
  import tcb_pkg::*;

  logic             stg_v;
  logic [WIDTH-1:0] stg_d;
  logic [AW-1:0]    wptr_q;
  logic [CW-1:0]    cnt_q;
  logic             full_q, trig_q, done_q;
  logic             acc, exhausted, last_slot;

  assign exhausted = trig_q && (cnt_q == '0);
  assign in_ready  = en && !done_q && !exhausted;
  assign acc       = in_valid && in_ready;
  assign last_slot = (wptr_q == AW'(DEPTH - 1));

  // staging register: one cycle between acceptance and the RAM write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_v <= 1'b0;
      stg_d <= '0;
    end else begin
      stg_v <= acc;
      if (acc) stg_d <= in_data;
    end
  end

  // write pointer and the wrap flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (start) full_q <= 1'b0;
      else if (stg_v && last_slot) full_q <= 1'b1;
      if (wptr_ld) wptr_q <= (wptr_val >= AW'(DEPTH - 1) + AW'(1) && DEPTH != (1 << AW)) ? '0 : wptr_val;
      else if (stg_v) wptr_q <= last_slot ? '0 : wptr_q + AW'(1);
    end
  end

  // trigger capture and post-trigger countdown
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (start) trig_q <= 1'b0;
      else if (en && trig) trig_q <= 1'b1;
      if (start) done_q <= 1'b0;
      else if (exhausted) done_q <= 1'b1;
      if (cnt_ld) cnt_q <= cnt_val;
      else if (acc && trig_q && cnt_q != '0) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign ram_we    = stg_v;
  assign ram_waddr = wptr_q;
  assign ram_wdata = stg_d;
  assign wptr      = wptr_q;
  assign cnt       = cnt_q;

  always_comb begin
    status = '0;
    status[ST_FULL]    = full_q;
    status[ST_TRIG]    = trig_q;
    status[ST_DONE]    = done_q;
    status[ST_DRAINED] = !stg_v;
  end

  // R2
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> en);
  // R7
  done_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !in_ready);
  // R5
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !start) |=> full_q);
  // R4
  wptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_q < AW'(DEPTH - 1) + AW'(1) || DEPTH == (1 << AW));
  // R10
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!full_q && !trig_q && !done_q));
  // R7
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_ld |=> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/tcb_regs.sv
module tcb_regs #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 24,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [3:0]       status,
  input  logic [AW-1:0]    wptr,
  input  logic [CW-1:0]    cnt,
  output logic             en,
  output logic             demux,
  output logic             start,
  output logic             wptr_ld,
  output logic             cnt_ld,
  output logic [AW-1:0]    ld_ptr,
  output logic [CW-1:0]    ld_cnt,
  output logic             ram_re,
  output logic [AW-1:0]    ram_raddr,
  input  logic [WIDTH-1:0] ram_q
);
  import tcb_pkg::*;

  tcb_addr_e     addr;
  logic [1:0]    ctrl_q;
  logic [AW-1:0] rptr_q;
  logic [31:0]   rd_q;
  logic          sel_ram_q;
  logic          wdata_unused;
  logic          rptr_ld, data_rd, rptr_last;

  assign addr         = tcb_addr_e'(reg_addr);
  assign wdata_unused = ^reg_wdata;
  assign ld_ptr       = reg_wdata[AW-1:0];
  assign ld_cnt       = reg_wdata[CW-1:0];
  assign wptr_ld      = reg_wr && addr == RA_WPTR;
  assign cnt_ld       = reg_wr && addr == RA_TCNT;
  assign rptr_ld      = reg_wr && addr == RA_RPTR;
  assign start        = reg_wr && addr == RA_CTRL && reg_wdata[0] && !ctrl_q[0];
  assign data_rd      = reg_rd && addr == RA_DATA;
  assign rptr_last    = (rptr_q == AW'(DEPTH - 1));
  assign en           = ctrl_q[0];
  assign demux        = ctrl_q[1];
  assign ram_re       = data_rd;
  assign ram_raddr    = rptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rptr_q <= '0;
    end else begin
      if (reg_wr && addr == RA_CTRL) ctrl_q <= reg_wdata[1:0];
      if (rptr_ld) rptr_q <= ld_ptr;
      else if (data_rd) rptr_q <= rptr_last ? '0 : rptr_q + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q      <= '0;
      sel_ram_q <= 1'b0;
    end else if (reg_rd) begin
      sel_ram_q <= (addr == RA_DATA);
      case (addr)
        RA_DEPTH:  rd_q <= 32'(DEPTH);
        RA_WIDTH:  rd_q <= 32'(WIDTH);
        RA_STATUS: rd_q <= 32'(status);
        RA_RPTR:   rd_q <= 32'(rptr_q);
        RA_WPTR:   rd_q <= 32'(wptr);
        RA_TCNT:   rd_q <= 32'(cnt);
        RA_CTRL:   rd_q <= 32'(ctrl_q);
        default:   rd_q <= '0;
      endcase
    end
  end

  assign reg_rdata = sel_ram_q ? 32'(ram_q) : rd_q;

  // R9
  rptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !rptr_ld) |=>
      rptr_q == (($past(rptr_q) == AW'(DEPTH - 1)) ? '0 : $past(rptr_q) + AW'(1)));
  // R3
  demux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && addr == RA_CTRL) |=> $stable(demux));
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 24,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  input  logic             trig_in,
  output logic             demux_mode,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata
);
  logic             en, start, wptr_ld, cnt_ld, ram_we, ram_re;
  logic [AW-1:0]    ld_ptr, wptr, ram_waddr, ram_raddr;
  logic [CW-1:0]    ld_cnt, cnt;
  logic [WIDTH-1:0] ram_wdata, ram_q;
  logic [3:0]       status;

  tcb_regs #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .status(status), .wptr(wptr), .cnt(cnt), .en(en), .demux(demux_mode),
    .start(start), .wptr_ld(wptr_ld), .cnt_ld(cnt_ld), .ld_ptr(ld_ptr),
    .ld_cnt(ld_cnt), .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_q(ram_q)
  );

  tcb_acq #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_acq (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .trig(trig_in),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .wptr_ld(wptr_ld), .wptr_val(ld_ptr), .cnt_ld(cnt_ld), .cnt_val(ld_cnt),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .wptr(wptr), .cnt(cnt), .status(status)
  );

  tcb_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_q)
  );
endmodule

// File: tb/tb_trace_capture_buf.sv
module tb_trace_capture_buf;
  localparam int DEPTH = 16;
  localparam int WIDTH = 24;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [WIDTH-1:0] in_data = '0;
  logic             in_ready;
  logic             trig_in = 1'b0;
  logic             demux_mode;
  logic [2:0]       reg_addr = '0;
  logic             reg_wr = 1'b0;
  logic             reg_rd = 1'b0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  trace_capture_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .trig_in(trig_in), .demux_mode(demux_mode),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #10 clk = ~clk;

  // reset-state table: {address, expected value}
  localparam logic [34:0] RST_TBL [0:6] = '{
    {3'd0, 32'd16}, {3'd1, 32'd24}, {3'd2, 32'd8}, {3'd4, 32'd0},
    {3'd5, 32'd0},  {3'd6, 32'd0},  {3'd7, 32'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic push(input logic [WIDTH-1:0] d, output bit acc);
    @(negedge clk); acc = in_ready;
    if (acc) begin in_valid = 1'b1; in_data = d; end
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_in = 1'b1;
    @(negedge clk); trig_in = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bit acc;
    int taken;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset-state table
    for (int i = 0; i < 7; i++) begin
      rd(RST_TBL[i][34:32], v);
      check("R1 reset read", v, RST_TBL[i][31:0]);
    end
    check("R2 ready low after reset", 32'(in_ready), 0);
    wr(3'd0, 32'h5); rd(3'd0, v); check("R1 depth write ignored", v, 16);
    wr(3'd1, 32'h7); rd(3'd1, v); check("R1 width write ignored", v, 24);

    // T1: capture without trigger, read back
    wr(3'd5, 0); wr(3'd6, 4); wr(3'd7, 1);
    check("R2 ready with enable", 32'(in_ready), 1);
    @(negedge clk); in_valid = 1'b1; in_data = 24'h100;
    @(negedge clk); in_valid = 1'b0; reg_addr = 3'd2; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    check("R8 drained low while staged", reg_rdata, 32'h0);
    push(24'h101, acc); push(24'h102, acc);
    rd(3'd2, v); check("R8 drained after stores", v, 32'h8);
    rd(3'd5, v); check("R4 wptr counts words", v, 3);
    wr(3'd7, 0);
    check("R2 ready low when disabled", 32'(in_ready), 0);
    wr(3'd4, 0);
    for (int j = 0; j < 3; j++) begin
      rd(3'd3, v); check("R11 data order", v, 32'h100 + 32'(j));
    end
    rd(3'd4, v); check("R9 rptr advanced", v, 3);

    // T2: trigger and countdown
    wr(3'd5, 0); wr(3'd6, 5); wr(3'd7, 1);
    for (int j = 0; j < 7; j++) push(24'h300 + 24'(j), acc);
    pulse_trig();
    taken = 0;
    for (int j = 0; j < 20; j++) begin
      push(24'h400 + 24'(j), acc);
      if (acc) taken++;
    end
    check("R7 words after trigger", 32'(taken), 5);
    rd(3'd2, v); check("R7 status complete", v, 32'hE);
    rd(3'd5, v); check("R4 wptr after trigger run", v, 12);
    rd(3'd6, v); check("R7 counter exhausted", v, 0);

    // T3: wrap
    wr(3'd7, 0); wr(3'd5, 0); wr(3'd6, 4); wr(3'd7, 1);
    rd(3'd2, v); check("R10 flags cleared on start", v, 32'h8);
    for (int j = 0; j < 15; j++) push(24'h200 + 24'(j), acc);
    rd(3'd2, v); check("R5 not full before last slot", v, 32'h8);
    push(24'h20F, acc);
    rd(3'd2, v); check("R5 full at last slot", v, 32'h9);
    rd(3'd5, v); check("R4 wptr wrapped", v, 0);
    for (int j = 16; j < 20; j++) push(24'h200 + 24'(j), acc);
    pulse_trig();
    for (int j = 20; j < 24; j++) push(24'h200 + 24'(j), acc);
    push(24'hBAD, acc);
    check("R7 refused after count", 32'(acc), 0);
    rd(3'd2, v); check("R5 status after wrap", v, 32'hF);
    rd(3'd5, v); check("R4 wptr points oldest", v, 8);
    wr(3'd4, 8);
    for (int j = 0; j < DEPTH; j++) begin
      rd(3'd3, v); check("R11 oldest-first readout", v, 32'h208 + 32'(j));
    end
    rd(3'd4, v); check("R9 rptr wraps", v, 8);

    // T4: trigger ignored while disabled, zero count
    wr(3'd7, 0); wr(3'd7, 1); wr(3'd7, 0);
    pulse_trig();
    rd(3'd2, v); check("R6 trigger ignored when disabled", v, 32'h8);
    wr(3'd6, 0); wr(3'd7, 1);
    check("R2 ready before trigger", 32'(in_ready), 1);
    pulse_trig();
    @(negedge clk);
    rd(3'd2, v); check("R7 zero count completes", v, 32'hE);
    check("R7 ready low at zero count", 32'(in_ready), 0);

    // R3 demux bit
    wr(3'd7, 3);
    check("R3 demux pin", 32'(demux_mode), 1);
    rd(3'd7, v); check("R3 control readback", v, 3);
    wr(3'd7, 1);
    check("R3 demux pin cleared", 32'(demux_mode), 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule